// File: doc/BRIEF.md
# CPU Low-Power Mode Controller

This block sequences the power modes of an 8051-style CPU core. Software writes a mode request into the power-control register through the core's special-function-register write port. The controller then moves from run into idle or stop on the following cycle, so the instruction that made the request completes first. In idle the CPU is held, but every clock keeps running. In stop the core and peripheral clocks are gated and the crystal amplifier is switched off.

Each mode has its own wake-up path. Idle ends on any enabled interrupt. Stop ends only on the interrupt lines that need no clock. On leaving stop, the amplifier is restarted first, and a parameterised settling period passes before the clocks come back and the CPU is released. Every wake-up produces a one-cycle indication that carries the index of the interrupt that caused it. The reset sources are merged into one system reset. That merge is aware of the current mode: the watchdog cannot reset while its clock is stopped, and the brownout flag is honoured in stop only when the band-gap reference is enabled.

The controller itself runs on an always-on clock. The CPU pipeline, the interrupt vectoring, the comparator and the oscillator lie outside it and appear only as ports.

Top module: `pmode_ctrl`

## Requirements
- R1: A write with address 8'h87 and data bit 1 set enters stop on the next cycle. The same write with only data bit 0 set enters idle. When both bits are set, stop wins. A write to any other address, or with neither bit set, leaves the block in run.
- R2: In idle, cpu_hold=1 while core_clk_en, periph_clk_en and osc_en all stay 1.
- R3: In idle, any request with its enable set returns the block to run on the next cycle. In that first run cycle, wake_valid is 1 for one cycle and wake_src gives the lowest set index of irq_req & irq_en. Requests whose enable is clear have no effect.
- R4: In stop, cpu_hold=1 and core_clk_en, periph_clk_en and osc_en are all 0.
- R5: In stop, only the non-clocked lines can wake the block. With the default mask these are index 0 (external 0), index 2 (external 1) and index 5 (power fail). Indices 1, 3 and 4 (timers, serial) are ignored.
- R6: The power-fail line (index 5) wakes stop only while bandgap_en=1.
- R7: A stop wake-up raises osc_en on the next cycle. cpu_hold then stays 1 and both clock enables stay 0 for STAB_CYCLES cycles in total. After that the block is in run, and wake_valid pulses with the source that ended stop.
- R8: sys_rst is high, in the same cycle, whenever any of these holds: por_rst; ext_rst; wdt_rst while the peripheral clock runs; or bod_low while the peripheral clock runs or bandgap_en=1.
- R9: A sys_rst returns the block to run on the next edge, from any mode and with no settling delay.
- R10: Register writes are ignored while cpu_hold=1.
- R11: While por_rst is high, and after it is released, the block is in run: cpu_hold=0, all enables 1, wake_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| por_rst | input | 1 | Power-on reset, asynchronous, active high |
| ext_rst | input | 1 | External reset pin, active high |
| wdt_rst | input | 1 | Watchdog reset request |
| bod_low | input | 1 | Supply-below-threshold comparator flag |
| bandgap_en | input | 1 | Band-gap reference select |
| sfr_we | input | 1 | Register write strobe |
| sfr_addr | input | SFR_AW | Register write address |
| sfr_wdata | input | SFR_DW | Register write data |
| irq_req | input | NUM_IRQ | Interrupt requests |
| irq_en | input | NUM_IRQ | Interrupt enables |
| cpu_hold | output | 1 | Freezes the program counter and fetch |
| core_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Timer, watchdog and serial clock enable |
| osc_en | output | 1 | Crystal amplifier enable |
| wake_valid | output | 1 | One-cycle wake-up indication |
| wake_src | output | SRC_W | Index of the waking interrupt |
| sys_rst | output | 1 | Merged system reset |

## Verification
A wrong mode state shows on the four enables and cpu_hold one cycle after the write or wake event that caused it, because those outputs decode the state register directly. A wrong settling count moves the rise of core_clk_en away from the cycle STAB_CYCLES after osc_en rises. A wrong wake mask shows up as a block that stays asleep, or wakes when it should not, on the cycle after the request. A mode-blind reset merge shows the same cycle on sys_rst.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_IDLE = 2'd1,
      PM_STOP = 2'd2,
      PM_WARM = 2'd3
   } pmode_e;

   function automatic logic pm_clocks_live(input pmode_e st);
      return (st == PM_RUN) || (st == PM_IDLE);
   endfunction

endpackage

// File: rtl/pmode_sfr_decode.sv
module pmode_sfr_decode #(
   parameter int unsigned SFR_AW   = 8,
   parameter int unsigned SFR_DW   = 8,
   parameter logic [SFR_AW-1:0] CTRL_ADDR = 8'h87,
   parameter int unsigned IDLE_BIT = 0,
   parameter int unsigned STOP_BIT = 1
) (
   input  logic              accept,
   input  logic              sfr_we,
   input  logic [SFR_AW-1:0] sfr_addr,
   input  logic [SFR_DW-1:0] sfr_wdata,
   output logic              go_idle,
   output logic              go_stop
);

   generate
      if (IDLE_BIT >= SFR_DW || STOP_BIT >= SFR_DW) begin : g_bad_bit
         $error("pmode_sfr_decode: mode bit outside data width");
      end
      if (IDLE_BIT == STOP_BIT) begin : g_same_bit
         $error("pmode_sfr_decode: idle and stop bits must differ");
      end
   endgenerate

   logic hit;

   always_comb begin
      hit     = accept && sfr_we && (sfr_addr == CTRL_ADDR);
      go_stop = hit && sfr_wdata[STOP_BIT];
      go_idle = hit && sfr_wdata[IDLE_BIT] && !sfr_wdata[STOP_BIT];
   end

endmodule

// File: rtl/pmode_wake.sv
module pmode_wake #(
   parameter int unsigned NUM_IRQ = 6,
   parameter logic [NUM_IRQ-1:0] ASYNC_MASK = 6'b100101,
   parameter int unsigned PF_IDX = 5,
   localparam int unsigned SRC_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
   input  logic               in_stop,
   input  logic               bandgap_en,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic [NUM_IRQ-1:0] irq_en,
   output logic               wake_any,
   output logic [SRC_W-1:0]   wake_idx
);

   generate
      if (PF_IDX >= NUM_IRQ) begin : g_bad_pf
         $error("pmode_wake: power-fail index outside request vector");
      end
      if (ASYNC_MASK == '0) begin : g_no_async
         $error("pmode_wake: stop mode would have no wake source");
      end
   endgenerate

   logic [NUM_IRQ-1:0] stop_ok;
   logic [NUM_IRQ-1:0] eff;

   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_mask
      if (ASYNC_MASK[g] && (g == PF_IDX)) begin : g_pf
         assign stop_ok[g] = bandgap_en;
      end else if (ASYNC_MASK[g]) begin : g_async
         assign stop_ok[g] = 1'b1;
      end else begin : g_clocked
         assign stop_ok[g] = 1'b0;
      end
   end

   always_comb begin
      eff      = irq_req & irq_en & (in_stop ? stop_ok : {NUM_IRQ{1'b1}});
      wake_any = |eff;
      wake_idx = '0;
      for (int i = NUM_IRQ - 1; i >= 0; i--) begin
         if (eff[i]) wake_idx = SRC_W'(i);
      end
   end

endmodule

// File: rtl/pmode_rst_merge.sv
module pmode_rst_merge (
   input  logic por_rst,
   input  logic ext_rst,
   input  logic wdt_rst,
   input  logic bod_low,
   input  logic bandgap_en,
   input  logic clocks_live,
   output logic sys_rst
);

   logic wdt_ok;
   logic bod_ok;

   always_comb begin
      wdt_ok  = wdt_rst && clocks_live;
      bod_ok  = bod_low && (clocks_live || bandgap_en);
      sys_rst = por_rst || ext_rst || wdt_ok || bod_ok;
   end

endmodule

// File: rtl/pmode_seq.sv
module pmode_seq
   import pmode_pkg::*;
#(
   parameter int unsigned STAB_CYCLES = 16,
   parameter int unsigned SRC_W = 3,
   localparam int unsigned CNT_W = (STAB_CYCLES > 1) ? $clog2(STAB_CYCLES) : 1
) (
   input  logic             clk,
   input  logic             por_rst,
   input  logic             sys_rst,
   input  logic             go_idle,
   input  logic             go_stop,
   input  logic             wake_any,
   input  logic [SRC_W-1:0] wake_idx,
   output pmode_e           state,
   output logic             wake_valid,
   output logic [SRC_W-1:0] wake_src
);

   generate
      if (STAB_CYCLES < 1) begin : g_bad_stab
         $error("pmode_seq: settling count must be at least one");
      end
   endgenerate

   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STAB_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [SRC_W-1:0] pend_q;

   always_ff @(posedge clk or posedge por_rst) begin
      if (por_rst) begin
         state      <= PM_RUN;
         cnt_q      <= '0;
         pend_q     <= '0;
         wake_valid <= 1'b0;
         wake_src   <= '0;
      end else if (sys_rst) begin
         state      <= PM_RUN;
         cnt_q      <= '0;
         wake_valid <= 1'b0;
      end else begin
         wake_valid <= 1'b0;
         unique case (state)
            PM_RUN: begin
               if (go_stop)      state <= PM_STOP;
               else if (go_idle) state <= PM_IDLE;
            end
            PM_IDLE: begin
               if (wake_any) begin
                  state      <= PM_RUN;
                  wake_valid <= 1'b1;
                  wake_src   <= wake_idx;
               end
            end
            PM_STOP: begin
               if (wake_any) begin
                  state  <= PM_WARM;
                  cnt_q  <= '0;
                  pend_q <= wake_idx;
               end
            end
            PM_WARM: begin
               if (cnt_q == CNT_LAST) begin
                  state      <= PM_RUN;
                  wake_valid <= 1'b1;
                  wake_src   <= pend_q;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: state <= PM_RUN;
         endcase
      end
   end

endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
   import pmode_pkg::*;
#(
   parameter int unsigned SFR_AW = 8,
   parameter int unsigned SFR_DW = 8,
   parameter logic [SFR_AW-1:0] CTRL_ADDR = 8'h87,
   parameter int unsigned IDLE_BIT = 0,
   parameter int unsigned STOP_BIT = 1,
   parameter int unsigned NUM_IRQ = 6,
   parameter logic [NUM_IRQ-1:0] ASYNC_MASK = 6'b100101,
   parameter int unsigned PF_IDX = 5,
   parameter int unsigned STAB_CYCLES = 16,
   localparam int unsigned SRC_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
   input  logic               clk,
   input  logic               por_rst,
   input  logic               ext_rst,
   input  logic               wdt_rst,
   input  logic               bod_low,
   input  logic               bandgap_en,
   input  logic               sfr_we,
   input  logic [SFR_AW-1:0]  sfr_addr,
   input  logic [SFR_DW-1:0]  sfr_wdata,
   input  logic [NUM_IRQ-1:0] irq_req,
   input  logic [NUM_IRQ-1:0] irq_en,
   output logic               cpu_hold,
   output logic               core_clk_en,
   output logic               periph_clk_en,
   output logic               osc_en,
   output logic               wake_valid,
   output logic [SRC_W-1:0]   wake_src,
   output logic               sys_rst
);

   pmode_e           state;
   logic             go_idle;
   logic             go_stop;
   logic             wake_any;
   logic [SRC_W-1:0] wake_idx;
   logic             clocks_live;

   assign clocks_live = pm_clocks_live(state);

   pmode_sfr_decode #(
      .SFR_AW(SFR_AW), .SFR_DW(SFR_DW), .CTRL_ADDR(CTRL_ADDR),
      .IDLE_BIT(IDLE_BIT), .STOP_BIT(STOP_BIT)
   ) i_decode (
      .accept    (state == PM_RUN),
      .sfr_we    (sfr_we),
      .sfr_addr  (sfr_addr),
      .sfr_wdata (sfr_wdata),
      .go_idle   (go_idle),
      .go_stop   (go_stop)
   );

   pmode_wake #(
      .NUM_IRQ(NUM_IRQ), .ASYNC_MASK(ASYNC_MASK), .PF_IDX(PF_IDX)
   ) i_wake (
      .in_stop    (state == PM_STOP),
      .bandgap_en (bandgap_en),
      .irq_req    (irq_req),
      .irq_en     (irq_en),
      .wake_any   (wake_any),
      .wake_idx   (wake_idx)
   );

   pmode_rst_merge i_rst (
      .por_rst     (por_rst),
      .ext_rst     (ext_rst),
      .wdt_rst     (wdt_rst),
      .bod_low     (bod_low),
      .bandgap_en  (bandgap_en),
      .clocks_live (clocks_live),
      .sys_rst     (sys_rst)
   );

   pmode_seq #(
      .STAB_CYCLES(STAB_CYCLES), .SRC_W(SRC_W)
   ) i_seq (
      .clk        (clk),
      .por_rst    (por_rst),
      .sys_rst    (sys_rst),
      .go_idle    (go_idle),
      .go_stop    (go_stop),
      .wake_any   (wake_any),
      .wake_idx   (wake_idx),
      .state      (state),
      .wake_valid (wake_valid),
      .wake_src   (wake_src)
   );

   always_comb begin
      cpu_hold      = (state != PM_RUN);
      core_clk_en   = clocks_live;
      periph_clk_en = clocks_live;
      osc_en        = (state != PM_STOP);
   end

endmodule

// File: rtl/pmode_chk.sv
module pmode_chk #(
   parameter int unsigned SFR_AW = 8,
   parameter int unsigned SFR_DW = 8,
   parameter logic [SFR_AW-1:0] CTRL_ADDR = 8'h87,
   parameter int unsigned IDLE_BIT = 0,
   parameter int unsigned STOP_BIT = 1,
   parameter int unsigned NUM_IRQ = 6,
   parameter int unsigned SRC_W = 3
) (
   input logic               clk,
   input logic               por_rst,
   input logic               ext_rst,
   input logic               wdt_rst,
   input logic               bod_low,
   input logic               bandgap_en,
   input logic               sfr_we,
   input logic [SFR_AW-1:0]  sfr_addr,
   input logic [SFR_DW-1:0]  sfr_wdata,
   input logic [NUM_IRQ-1:0] irq_req,
   input logic [NUM_IRQ-1:0] irq_en,
   input logic               cpu_hold,
   input logic               core_clk_en,
   input logic               periph_clk_en,
   input logic               osc_en,
   input logic               wake_valid,
   input logic [SRC_W-1:0]   wake_src,
   input logic               sys_rst
);

   logic wr_hit;
   logic in_idle;
   assign wr_hit  = sfr_we && (sfr_addr == CTRL_ADDR) && !cpu_hold && !sys_rst;
   assign in_idle = cpu_hold && core_clk_en;

   p_stop_entry_r1: assert property (@(posedge clk) disable iff (por_rst)
      (wr_hit && sfr_wdata[STOP_BIT]) |=> (cpu_hold && !osc_en && !core_clk_en && !periph_clk_en));

   p_idle_entry_r2: assert property (@(posedge clk) disable iff (por_rst)
      (wr_hit && sfr_wdata[IDLE_BIT] && !sfr_wdata[STOP_BIT])
      |=> (cpu_hold && core_clk_en && periph_clk_en && osc_en));

   p_idle_wake_r3: assert property (@(posedge clk) disable iff (por_rst)
      (in_idle && |(irq_req & irq_en) && !sys_rst) |=> (!cpu_hold && wake_valid));

   p_wake_released_r3: assert property (@(posedge clk) disable iff (por_rst)
      wake_valid |-> (!cpu_hold && core_clk_en && osc_en));

   p_warm_held_r7: assert property (@(posedge clk) disable iff (por_rst)
      (osc_en && !core_clk_en) |-> cpu_hold);

   p_wdt_masked_r8: assert property (@(posedge clk) disable iff (por_rst)
      (!periph_clk_en && wdt_rst && !ext_rst && !bod_low) |-> !sys_rst);

   p_reset_run_r9: assert property (@(posedge clk) disable iff (por_rst)
      sys_rst |=> (!cpu_hold && core_clk_en && !wake_valid));

   p_ignore_write_r10: assert property (@(posedge clk) disable iff (por_rst)
      (in_idle && !sys_rst && !(|(irq_req & irq_en))) |=> in_idle);

   always @(posedge clk) begin
      if (por_rst) begin
         p_por_reset_r11: assert (sys_rst && !cpu_hold);
      end
   end

endmodule

bind pmode_ctrl pmode_chk #(
   .SFR_AW(SFR_AW), .SFR_DW(SFR_DW), .CTRL_ADDR(CTRL_ADDR),
   .IDLE_BIT(IDLE_BIT), .STOP_BIT(STOP_BIT), .NUM_IRQ(NUM_IRQ), .SRC_W(SRC_W)
) i_pmode_chk (.*);

// File: tb/test_pmode_ctrl.sv
`timescale 1ns/1ps
module test_pmode_ctrl;

   localparam int N    = 6;
   localparam int STAB = 16;

   logic       clk = 1'b0;
   logic       por_rst = 1'b1, ext_rst = 1'b0, wdt_rst = 1'b0, bod_low = 1'b0;
   logic       bandgap_en = 1'b0, sfr_we = 1'b0;
   logic [7:0] sfr_addr = 8'h00, sfr_wdata = 8'h00;
   logic [N-1:0] irq_req = '0, irq_en = '0;
   logic       cpu_hold, core_clk_en, periph_clk_en, osc_en, wake_valid, sys_rst;
   logic [2:0] wake_src;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // model: 0 run, 1 idle, 2 stop, 3 warm
   int m_st = 0, m_cnt = 0, m_src = 0, m_pend = 0;
   bit m_wv = 0;

   always #4 clk = ~clk;

   pmode_ctrl i_pmode_ctrl (
      .clk(clk), .por_rst(por_rst), .ext_rst(ext_rst), .wdt_rst(wdt_rst),
      .bod_low(bod_low), .bandgap_en(bandgap_en), .sfr_we(sfr_we),
      .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .irq_req(irq_req),
      .irq_en(irq_en), .cpu_hold(cpu_hold), .core_clk_en(core_clk_en),
      .periph_clk_en(periph_clk_en), .osc_en(osc_en), .wake_valid(wake_valid),
      .wake_src(wake_src), .sys_rst(sys_rst)
   );

   function automatic bit f_rst(int st);
      bit live = (st <= 1);
      return por_rst | ext_rst | (wdt_rst & live) | (bod_low & (live | bandgap_en));
   endfunction

   function automatic logic [N-1:0] f_mask(int st);
      if (st == 2) return 6'b000101 | (bandgap_en ? 6'b100000 : 6'b000000);
      return '1;
   endfunction

   function automatic int f_lowest(logic [N-1:0] v);
      for (int i = N - 1; i >= 0; i--) if (v[i]) f_lowest = i;
   endfunction

   task automatic chk(string tag, string what, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
      end
   endtask

   // Called at a negedge with inputs already driven; ends at the next negedge.
   task automatic step(string tag);
      bit r;
      logic [N-1:0] p;
      #1;
      r = f_rst(m_st);
      chk(tag, "sys_rst", sys_rst, r);
      @(posedge clk);
      if (r) begin
         m_st = 0; m_cnt = 0; m_wv = 0;
      end else begin
         m_wv = 0;
         case (m_st)
            0: if (sfr_we && sfr_addr == 8'h87) begin
                  if (sfr_wdata[1]) m_st = 2;
                  else if (sfr_wdata[0]) m_st = 1;
               end
            1: begin
               p = irq_req & irq_en;
               if (p != 0) begin m_st = 0; m_wv = 1; m_src = f_lowest(p); end
            end
            2: begin
               p = irq_req & irq_en & f_mask(2);
               if (p != 0) begin m_st = 3; m_cnt = 0; m_pend = f_lowest(p); end
            end
            default: begin
               if (m_cnt == STAB - 1) begin m_st = 0; m_wv = 1; m_src = m_pend; end
               else m_cnt++;
            end
         endcase
      end
      @(negedge clk);
      chk(tag, "cpu_hold", cpu_hold, m_st != 0);
      chk(tag, "core_clk_en", core_clk_en, m_st <= 1);
      chk(tag, "periph_clk_en", periph_clk_en, m_st <= 1);
      chk(tag, "osc_en", osc_en, m_st != 2);
      chk(tag, "wake_valid", wake_valid, m_wv);
      if (m_wv) chk(tag, "wake_src", wake_src, m_src);
   endtask

   task automatic wr(string tag, logic [7:0] a, logic [7:0] d);
      sfr_we = 1'b1; sfr_addr = a; sfr_wdata = d;
      step(tag);
      sfr_we = 1'b0;
   endtask

   task automatic quiet(string tag, int n);
      for (int i = 0; i < n; i++) step(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hung run expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      // R11: reset state while power-on reset is high and after release
      step("R11");
      por_rst = 1'b0;
      quiet("R11", 2);

      // R1: wrong address and empty data leave run
      wr("R1", 8'h86, 8'h02); quiet("R1", 1);
      wr("R1", 8'h87, 8'h00); quiet("R1", 1);
      // R1: both bits -> stop wins; R4 stop outputs
      wr("R1", 8'h87, 8'h03); quiet("R4", 3);
      // R9: external reset leaves stop with no delay
      ext_rst = 1'b1; step("R9"); ext_rst = 1'b0; quiet("R9", 1);

      // R2: idle; R10: write while held ignored
      wr("R2", 8'h87, 8'h01); quiet("R2", 2);
      wr("R10", 8'h87, 8'h02); quiet("R10", 2);
      // R3: disabled request ignored, then lowest enabled index wins
      irq_req = 6'b010100; irq_en = 6'b000000; quiet("R3", 2);
      irq_en = 6'b010100; step("R3");
      irq_req = '0; quiet("R3", 1);

      // R5: timer request ignored in stop, external 1 wakes; R7 settling
      wr("R5", 8'h87, 8'h02);
      irq_req = 6'b011010; irq_en = 6'b111111; quiet("R5", 3);
      irq_req = 6'b000100; step("R5"); irq_req = '0;
      quiet("R7", STAB + 1);

      // R6: power-fail needs the band-gap
      bandgap_en = 1'b0;
      wr("R6", 8'h87, 8'h02);
      irq_req = 6'b100000; quiet("R6", 3);
      bandgap_en = 1'b1; step("R6"); irq_req = '0;
      quiet("R7", STAB + 1);

      // R8: watchdog and brownout gating
      bandgap_en = 1'b0;
      wr("R8", 8'h87, 8'h02);
      wdt_rst = 1'b1; quiet("R8", 2); wdt_rst = 1'b0;
      bod_low = 1'b1; quiet("R8", 2);
      bandgap_en = 1'b1; step("R8"); bod_low = 1'b0; quiet("R8", 1);
      bandgap_en = 1'b0; bod_low = 1'b1; step("R8"); bod_low = 1'b0;
      wr("R8", 8'h87, 8'h01); wdt_rst = 1'b1; step("R8"); wdt_rst = 1'b0;
      quiet("R9", 1);

      // random phase
      for (int k = 0; k < 4000; k++) begin
         string tag;
         irq_req    = ($urandom % 10 == 0) ? N'($urandom) : '0;
         irq_en     = N'($urandom);
         bandgap_en = $urandom % 2;
         ext_rst    = ($urandom % 300 == 0);
         wdt_rst    = ($urandom % 200 == 0);
         bod_low    = ($urandom % 150 == 0);
         por_rst    = ($urandom % 700 == 0);
         sfr_we     = ($urandom % 5 == 0);
         sfr_addr   = ($urandom % 4 == 0) ? 8'($urandom) : 8'h87;
         sfr_wdata  = 8'($urandom);
         case (m_st)
            0: tag = "R1";
            1: tag = "R3";
            2: tag = "R5";
            default: tag = "R7";
         endcase
         step(tag);
      end
      por_rst = 1'b0; ext_rst = 1'b0; wdt_rst = 1'b0; bod_low = 1'b0; sfr_we = 1'b0;

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule